// File: doc/BRIEF.md
# Power Event Status and Interrupt Block

This block holds two 16-bit power-management registers on a small I/O port bus: an event status word and an event enable word. A status flag and its matching enable flag, both set, raise a level-sensitive system control interrupt (SCI). Only one hardware source feeds the status word: a one-cycle pulse from an external power button. Firmware services the interrupt in three steps. It reads the status word. It acknowledges flags by writing ones to them. It masks sources through the enable word.

A bus access is one cycle with the strobe high. It carries an address, a byte count, a direction and write data. Read data and the error flag come out of registers and are valid in the cycle after the strobe. The SCI output is a register loaded from the next-state values of both registers. It therefore settles in the cycle after any write or button pulse that changes it. It drops back low only when no armed pair is left.

Top module: `pwr_evt_sci`

## Requirements
- R1: After reset the status word, enable word, SCI output, read data and error flag are all zero.
- R2: An access to address 0x400 or 0x402 with a byte count other than 2 sets the error flag in the next cycle. That access returns read data 0 and changes no register.
- R3: A 2-byte write to the status word at 0x400 clears each bit written as 1, but only among bits 15, 10, 9, 8 and 4. A bit written as 0 keeps its value, and bits 0 and 5 cannot be cleared by any write.
- R4: A 2-byte write to the enable word at 0x402 keeps only bits 8 and 5 of the write data. Every other enable bit reads back as 0.
- R5: A power-button pulse sets status bit 8. A pulse that arrives while bit 8 is already set changes nothing.
- R6: The SCI output is high exactly when status and enable both have a 1 in one of bits 0, 5, 8, 9 or 10. It takes its new value in the cycle after the write or pulse that changes it.
- R7: If a power-button pulse and a status write clearing bit 8 fall in the same cycle, bit 8 ends up set.
- R8: A 2-byte read returns the addressed word zero-extended to 32 bits in the next cycle and has no side effect on either register.
- R9: An access to any other address raises no error, returns read data 0 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| io_valid | input | 1 | Access strobe, one cycle per access |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_bytes | input | 3 | Byte count of the access |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid the cycle after the strobe |
| io_err | output | 1 | Size error, valid the cycle after the strobe |
| pwrbtn_pulse | input | 1 | One-cycle power-button event |
| sci_o | output | 1 | Level system control interrupt, active high |

## Verification
Each access or button pulse is applied for one clock edge. Register contents, read data, the error flag and the SCI level all change on that same edge, so every result is due one cycle after the stimulus. The bench drives inputs on the falling edge and holds them across exactly one rising edge. It samples on the next falling edge, which is where both the size-error flag and the SCI response of that stimulus are first visible. Register contents are then confirmed with a separate read, whose data is sampled one falling edge after that read's own strobe.

// File: rtl/pwrevt_pkg.sv
`timescale 1ns/1ps
package pwrevt_pkg;
  localparam int REG_W = 16;
  localparam int PWRBTN_BIT = 8;
  // status bits that a write-one may clear
  localparam logic [REG_W-1:0] STS_CLR_MASK = 16'h8710;
  // enable bits that a write may store
  localparam logic [REG_W-1:0] EN_WR_MASK = 16'h0120;
  // status/enable pairs that can raise the interrupt
  localparam logic [REG_W-1:0] SCI_PAIR_MASK = 16'h0721;

  function automatic logic sci_need(input logic [REG_W-1:0] sts,
                                    input logic [REG_W-1:0] en);
    return |(sts & en & SCI_PAIR_MASK);
  endfunction
endpackage

// File: rtl/pwrevt_rst_sync.sv
`timescale 1ns/1ps
module pwrevt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pwrevt_bus_dec.sv
`timescale 1ns/1ps
module pwrevt_bus_dec #(
  parameter int          ADDR_W    = 16,
  parameter int          CNT_W     = 3,
  parameter logic [15:0] BASE_ADDR = 16'h0400,
  parameter int          ACC_BYTES = 2
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  bytes_i,
  output logic              sts_wr_o,
  output logic              sts_rd_o,
  output logic              en_wr_o,
  output logic              en_rd_o,
  output logic              size_err_o
);
  localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(BASE_ADDR + 16'd2);
  localparam logic [CNT_W-1:0]  GOOD_CNT = CNT_W'(ACC_BYTES);

  logic hit_sts, hit_en, size_ok;

  always_comb begin
    hit_sts    = valid_i && (addr_i == STS_ADDR);
    hit_en     = valid_i && (addr_i == EN_ADDR);
    size_ok    = (bytes_i == GOOD_CNT);
    sts_wr_o   = hit_sts && size_ok && write_i;
    sts_rd_o   = hit_sts && size_ok && !write_i;
    en_wr_o    = hit_en && size_ok && write_i;
    en_rd_o    = hit_en && size_ok && !write_i;
    size_err_o = (hit_sts || hit_en) && !size_ok;
  end
endmodule

// File: rtl/pwrevt_status_reg.sv
`timescale 1ns/1ps
module pwrevt_status_reg
  import pwrevt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_we_i,
  input  logic [REG_W-1:0] clr_data_i,
  input  logic             btn_i,
  output logic [REG_W-1:0] sts_q_o,
  output logic [REG_W-1:0] sts_d_o
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    localparam bit CAN_CLR = STS_CLR_MASK[i];
    localparam bit HAS_SET = (i == PWRBTN_BIT);
    logic bit_q, bit_d;

    always_comb begin
      bit_d = bit_q;
      if (CAN_CLR && clr_we_i && clr_data_i[i]) bit_d = 1'b0;
      if (HAS_SET && btn_i) bit_d = 1'b1;  // event beats clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= bit_d;
    end

    assign sts_q_o[i] = bit_q;
    assign sts_d_o[i] = bit_d;
  end

  AST_BTN_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    btn_i |=> sts_q_o[PWRBTN_BIT]); // R5
  AST_TIMER_NOT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sts_q_o[0])); // R3
  AST_GLOBAL_NOT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sts_q_o[5])); // R3
  AST_CLEAR_LOSES_TO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_i && clr_we_i && clr_data_i[PWRBTN_BIT]) |=> sts_q_o[PWRBTN_BIT]); // R7
endmodule

// File: rtl/pwrevt_enable_reg.sv
`timescale 1ns/1ps
module pwrevt_enable_reg
  import pwrevt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] en_q_o,
  output logic [REG_W-1:0] en_d_o
);
  logic [REG_W-1:0] en_q;

  always_comb begin
    en_d_o = en_q;
    if (we_i) en_d_o = wdata_i & EN_WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d_o;
  end

  assign en_q_o = en_q;

  AST_EN_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~EN_WR_MASK) == '0); // R4
endmodule

// File: rtl/pwr_evt_sci.sv
`timescale 1ns/1ps
module pwr_evt_sci
  import pwrevt_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 32,
  parameter int          CNT_W     = 3,
  parameter logic [15:0] BASE_ADDR = 16'h0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_valid,
  input  logic              io_write,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [CNT_W-1:0]  io_bytes,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_err,
  input  logic              pwrbtn_pulse,
  output logic              sci_o
);
  localparam int PAD_W = DATA_W - REG_W;

  logic             rst_s_n;
  logic             sts_wr, sts_rd, en_wr, en_rd, size_err;
  logic [REG_W-1:0] sts_q, sts_d, en_q, en_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic             err_q, sci_q, sci_d;

  pwrevt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  pwrevt_bus_dec #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BASE_ADDR(BASE_ADDR), .ACC_BYTES(2)
  ) u_dec (
    .valid_i(io_valid), .write_i(io_write), .addr_i(io_addr), .bytes_i(io_bytes),
    .sts_wr_o(sts_wr), .sts_rd_o(sts_rd), .en_wr_o(en_wr), .en_rd_o(en_rd),
    .size_err_o(size_err));

  pwrevt_status_reg u_sts (
    .clk(clk), .rst_n(rst_s_n), .clr_we_i(sts_wr), .clr_data_i(io_wdata[REG_W-1:0]),
    .btn_i(pwrbtn_pulse), .sts_q_o(sts_q), .sts_d_o(sts_d));

  pwrevt_enable_reg u_en (
    .clk(clk), .rst_n(rst_s_n), .we_i(en_wr), .wdata_i(io_wdata[REG_W-1:0]),
    .en_q_o(en_q), .en_d_o(en_d));

  // next-state logic
  always_comb begin
    sci_d   = sci_need(sts_d, en_d);
    rdata_d = '0;
    if (sts_rd)     rdata_d = {{PAD_W{1'b0}}, sts_q};
    else if (en_rd) rdata_d = {{PAD_W{1'b0}}, en_q};
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
      sci_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= size_err;
      if (sci_d != sci_q) sci_q <= sci_d;  // level change only
    end
  end

  assign io_rdata = rdata_q;
  assign io_err   = err_q;
  assign sci_o    = sci_q;

  AST_SCI_NEEDS_ARMED_PAIR: assert property (@(posedge clk) disable iff (!rst_s_n)
    sci_q |-> (|(sts_q & en_q & SCI_PAIR_MASK))); // R6
  AST_SCI_LOW_WHEN_DISARMED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!sci_q) |-> ((sts_q & en_q & SCI_PAIR_MASK) == '0)); // R6
  AST_SIZE_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (size_err && !pwrbtn_pulse) |=> ($stable(sts_q) && $stable(en_q))); // R2
  AST_ERR_GIVES_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_s_n)
    io_err |-> (io_rdata == '0)); // R2
  AST_READ_ZERO_EXTENDED: assert property (@(posedge clk) disable iff (!rst_s_n)
    io_rdata[DATA_W-1:REG_W] == '0); // R8
endmodule

// File: tb/tb_pwr_evt_sci.sv
`timescale 1ns/1ps
module tb_pwr_evt_sci;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_valid, io_write, pwrbtn_pulse;
  logic [15:0] io_addr;
  logic [2:0]  io_bytes;
  logic [31:0] io_wdata, io_rdata;
  logic        io_err, sci_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [15:0] A_STS = 16'h0400;
  localparam logic [15:0] A_EN  = 16'h0402;

  always #4 clk = ~clk;

  pwr_evt_sci dut (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .io_bytes(io_bytes), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_err(io_err), .pwrbtn_pulse(pwrbtn_pulse),
    .sci_o(sci_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one access held across one rising edge, outputs sampled on next falling edge
  task automatic access(input logic wr, input logic [15:0] a, input logic [2:0] nb,
                        input logic [31:0] d, input logic btn);
    io_valid = 1'b1; io_write = wr; io_addr = a; io_bytes = nb; io_wdata = d;
    pwrbtn_pulse = btn;
    @(posedge clk); @(negedge clk);
    io_valid = 1'b0; pwrbtn_pulse = 1'b0; io_wdata = '0;
  endtask

  task automatic press();
    pwrbtn_pulse = 1'b1;
    @(posedge clk); @(negedge clk);
    pwrbtn_pulse = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
    access(1'b0, a, 3'd2, 32'h0, 1'b0);
    check(req, io_rdata, exp);
    check({req, " err"}, {31'b0, io_err}, 32'h0);
  endtask

  task automatic t_reset();
    check("R1 sci", {31'b0, sci_o}, 0);
    check("R1 err", {31'b0, io_err}, 0);
    check("R1 rdata", io_rdata, 0);
    read_chk("R1 status", A_STS, 32'h0);
    read_chk("R1 enable", A_EN, 32'h0);
  endtask

  task automatic t_enable_mask();
    access(1'b1, A_EN, 3'd2, 32'hFFFF_FFFF, 1'b0);
    read_chk("R4 enable keeps 8,5", A_EN, 32'h0000_0120);
    access(1'b1, A_EN, 3'd2, 32'h0000_DEDF, 1'b0);
    read_chk("R4 enable drops others", A_EN, 32'h0);
  endtask

  task automatic t_button_sci();
    access(1'b1, A_EN, 3'd2, 32'h0000_0100, 1'b0);
    check("R6 armed no event", {31'b0, sci_o}, 0);
    press();
    check("R6 sci after press", {31'b0, sci_o}, 1);
    read_chk("R5 status set", A_STS, 32'h0000_0100);
    press();
    read_chk("R5 second press ignored", A_STS, 32'h0000_0100);
    read_chk("R8 read no side effect", A_STS, 32'h0000_0100);
    check("R8 sci held", {31'b0, sci_o}, 1);
  endtask

  task automatic t_clear();
    access(1'b1, A_STS, 3'd2, 32'h0000_0000, 1'b0);
    check("R3 zero write keeps sci", {31'b0, sci_o}, 1);
    read_chk("R3 zero write keeps bit", A_STS, 32'h0000_0100);
    access(1'b1, A_STS, 3'd2, 32'h0000_0100, 1'b0);
    check("R6 sci drops on clear", {31'b0, sci_o}, 0);
    read_chk("R3 bit cleared", A_STS, 32'h0);
  endtask

  task automatic t_enable_gating();
    access(1'b1, A_EN, 3'd2, 32'h0, 1'b0);
    press();
    check("R6 disarmed no sci", {31'b0, sci_o}, 0);
    access(1'b1, A_EN, 3'd2, 32'h0000_0100, 1'b0);
    check("R6 arm raises sci", {31'b0, sci_o}, 1);
    access(1'b1, A_EN, 3'd2, 32'h0000_0020, 1'b0);
    check("R6 disarm drops sci", {31'b0, sci_o}, 0);
    access(1'b1, A_EN, 3'd2, 32'h0000_0100, 1'b0);
    check("R6 rearm", {31'b0, sci_o}, 1);
  endtask

  task automatic t_size_err();
    access(1'b1, A_EN, 3'd1, 32'h0, 1'b0);
    check("R2 byte write err", {31'b0, io_err}, 1);
    check("R2 enable kept sci", {31'b0, sci_o}, 1);
    access(1'b1, A_STS, 3'd4, 32'hFFFF, 1'b0);
    check("R2 dword write err", {31'b0, io_err}, 1);
    access(1'b0, A_STS, 3'd4, 32'h0, 1'b0);
    check("R2 dword read err", {31'b0, io_err}, 1);
    check("R2 dword read data", io_rdata, 0);
    read_chk("R2 status kept", A_STS, 32'h0000_0100);
    read_chk("R2 enable kept", A_EN, 32'h0000_0100);
  endtask

  task automatic t_race();
    access(1'b1, A_STS, 3'd2, 32'h0000_0100, 1'b1);
    read_chk("R7 event beats clear", A_STS, 32'h0000_0100);
    check("R7 sci stays", {31'b0, sci_o}, 1);
  endtask

  task automatic t_unmapped();
    access(1'b1, 16'h0404, 3'd2, 32'hFFFF, 1'b0);
    check("R9 no err write", {31'b0, io_err}, 0);
    access(1'b0, 16'h0401, 3'd1, 32'h0, 1'b0);
    check("R9 no err read", {31'b0, io_err}, 0);
    check("R9 read data zero", io_rdata, 0);
    read_chk("R9 status kept", A_STS, 32'h0000_0100);
    access(1'b1, A_STS, 3'd2, 32'hFFFF_FFFF, 1'b0);
    read_chk("R3 all-ones write clears", A_STS, 32'h0);
    check("R6 sci low at end", {31'b0, sci_o}, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_valid = 1'b0; io_write = 1'b0; io_addr = '0;
    io_bytes = '0; io_wdata = '0; pwrbtn_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable_mask();
    t_button_sci();
    t_clear();
    t_enable_gating();
    t_size_err();
    t_race();
    t_unmapped();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule